// File: doc/BRIEF.md
# USB Token Decoder and Address Filter

This block sits behind a low-speed (1.5 Mbps) USB receive path. That path has already undone the line coding, stripped the stuffed bits and checked the token CRC5. The block accepts a token packet as two strobed pieces: a PID byte, then the 11-bit address/endpoint field together with the upstream CRC5 error flag. It checks the PID, classifies it as SETUP, IN or OUT, and compares the address with a programmable 7-bit device address. When the token is accepted, it raises a one-cycle pulse for the token type together with the endpoint number.

A CPU-side configuration register holds an enable bit and the device address. While the enable bit is clear, the block answers no traffic and asks the transceiver to power down. A USB bus reset clears the whole register. Each accepted token also sets a sticky per-type flag, which the CPU clears with a write-one-to-clear strobe.

Top module: `usb_token_filter`

## Requirements
- R1: After reset, cfg_rdata is 0, xcvr_pdn is 1, tok_flags is 0 and tok_pulse is 0.
- R2: A cfg_we write of cfg_wdata appears on cfg_rdata on the next cycle. Bit 7 is the enable bit and bits 6:0 are the device address.
- R3: A bus_reset clears the whole configuration register on the next cycle. It takes priority over a cfg_we in the same cycle.
- R4: xcvr_pdn is 1 exactly when the enable bit is 0.
- R5: A pid_valid byte followed by a field_valid strobe forms an accepted token when all hold: the PID is SETUP, IN or OUT; crc5_err is 0; the enable bit is 1; field_bits[6:0] equals the device address. In the cycle after the field_valid strobe, tok_pulse carries a single bit: bit 0 for OUT (PID low nibble 0001), bit 1 for IN (1001), bit 2 for SETUP (1101). In that same cycle tok_ep equals field_bits[10:7]. In all other cycles tok_pulse is 0.
- R6: A token whose field_bits[6:0] differs from the device address produces no pulse and sets no flag.
- R7: While the enable bit is 0, no token produces a pulse or sets a flag, even when the address matches.
- R8: A PID whose upper nibble is not the bitwise complement of its lower nibble, or whose lower nibble is not one of the three token codes, produces no pulse and sets no flag.
- R9: A token whose field arrives with crc5_err set produces no pulse and sets no flag.
- R10: Each accepted token sets the matching tok_flags bit, with the same bit order as tok_pulse. The bit stays set until a flag_clr strobe has a 1 in that position. A set in the same cycle as a clear wins.
- R11: A field_valid strobe consumes the stored PID. A further field_valid with no new pid_valid produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset indication; clears the configuration register |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Write data: bit 7 enable, bits 6:0 device address |
| cfg_rdata | output | 8 | Current configuration register contents |
| xcvr_pdn | output | 1 | Transceiver power-down request |
| pid_valid | input | 1 | Strobe: pid_byte holds a received PID |
| pid_byte | input | 8 | Received PID byte |
| field_valid | input | 1 | Strobe: field_bits and crc5_err hold the token field |
| field_bits | input | 11 | Token field: bits 6:0 address, bits 10:7 endpoint, bit 0 received first |
| crc5_err | input | 1 | Upstream CRC5 failure for this token field |
| flag_clr | input | 3 | Write-one-to-clear strobes for tok_flags |
| tok_pulse | output | 3 | One-cycle accepted-token pulse: bit 0 OUT, bit 1 IN, bit 2 SETUP |
| tok_ep | output | 4 | Endpoint number of the last accepted token |
| tok_flags | output | 3 | Sticky token-type flags, same bit order as tok_pulse |

## Verification
The hardest case to reach from the ports is a clear strobe landing in the very cycle a new token sets the same flag. The bench sets this up by holding flag_clr high for a bit during the field_valid cycle of a matching token of that type, so the set and the clear meet at one clock edge. A second hard case is a stray field strobe with no PID before it. The bench reaches it by repeating field_valid right after an accepted token and checking that tok_pulse stays at 0. The register priority case is forced the same way, by asserting bus_reset and cfg_we together.

// File: rtl/usb_tok_pkg.sv
// Package: shared types and PID decoding for the USB token filter.
// Assumes PIDs arrive as full bytes: low nibble is the code, high nibble its check.
package usb_tok_pkg;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_SETUP = 2'd3
    } tok_kind_e;

    localparam logic [3:0] PID_CODE_OUT   = 4'b0001;
    localparam logic [3:0] PID_CODE_IN    = 4'b1001;
    localparam logic [3:0] PID_CODE_SETUP = 4'b1101;

    localparam int NUM_KINDS = 3;

    // Classify a PID byte; anything that fails the nibble check or is not a token is TK_NONE.
    function automatic tok_kind_e classify_pid(input logic [7:0] pid);
        tok_kind_e k;
        k = TK_NONE;
        if (pid[7:4] == ~pid[3:0]) begin
            case (pid[3:0])
                PID_CODE_OUT:   k = TK_OUT;
                PID_CODE_IN:    k = TK_IN;
                PID_CODE_SETUP: k = TK_SETUP;
                default:        k = TK_NONE;
            endcase
        end
        return k;
    endfunction

    // Map a token kind to its one-hot flag position (bit 0 OUT, bit 1 IN, bit 2 SETUP).
    function automatic logic [NUM_KINDS-1:0] kind_onehot(input tok_kind_e k);
        logic [NUM_KINDS-1:0] v;
        v = '0;
        case (k)
            TK_OUT:   v[0] = 1'b1;
            TK_IN:    v[1] = 1'b1;
            TK_SETUP: v[2] = 1'b1;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/usb_tok_cfg.sv
// Module: configuration register holding the enable bit (MSB) and device address.
// Assumes bus_reset is already synchronous to clk; it outranks a CPU write.
module usb_tok_cfg #(
    parameter int ADDR_W = 7,
    localparam int CFG_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  q,
    output logic              enable,
    output logic [ADDR_W-1:0] dev_addr
);

    // Register update: reset and bus reset clear it, otherwise a write loads it.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

    // Field split of the stored value.
    always_comb begin
        enable   = q[CFG_W-1];
        dev_addr = q[ADDR_W-1:0];
    end

endmodule

// File: rtl/usb_tok_pid.sv
// Module: captures the PID of the token in flight and holds its classification.
// Assumes the PID strobe precedes the field strobe; a field strobe consumes the PID.
module usb_tok_pid
    import usb_tok_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pid_valid,
    input  logic [7:0] pid_byte,
    input  logic       field_valid,
    output logic       armed,
    output tok_kind_e  kind
);

    // Hold the decoded kind of the latest PID and whether a field may still use it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            kind  <= TK_NONE;
        end else if (pid_valid) begin
            armed <= 1'b1;
            kind  <= classify_pid(pid_byte);
        end else if (field_valid) begin
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_tok_flags.sv
// Module: sticky per-type token flags with write-one-to-clear; set beats clear.
// Assumes set pulses are one cycle wide and already one-hot.
module usb_tok_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky bit: set has priority over a simultaneous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/usb_token_filter.sv
// Module: top of the USB token decoder and address filter.
// Assumes upstream delivers a PID strobe and a later field strobe per token,
// with line decoding, unstuffing and the CRC5 check already done.
module usb_token_filter
    import usb_tok_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4,
    localparam int FIELD_W = ADDR_W + EP_W,
    localparam int CFG_W   = ADDR_W + 1,
    localparam int NK      = NUM_KINDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_reset,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic               xcvr_pdn,
    input  logic               pid_valid,
    input  logic [7:0]         pid_byte,
    input  logic               field_valid,
    input  logic [FIELD_W-1:0] field_bits,
    input  logic               crc5_err,
    input  logic [NK-1:0]      flag_clr,
    output logic [NK-1:0]      tok_pulse,
    output logic [EP_W-1:0]    tok_ep,
    output logic [NK-1:0]      tok_flags
);

    logic              enable;
    logic [ADDR_W-1:0] dev_addr;
    logic              pid_armed;
    tok_kind_e         pid_kind;
    logic              accept;
    logic [NK-1:0]     hit_vec;

    usb_tok_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_reset(bus_reset),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .q        (cfg_rdata),
        .enable   (enable),
        .dev_addr (dev_addr)
    );

    usb_tok_pid u_pid (
        .clk        (clk),
        .rst_n      (rst_n),
        .pid_valid  (pid_valid),
        .pid_byte   (pid_byte),
        .field_valid(field_valid),
        .armed      (pid_armed),
        .kind       (pid_kind)
    );

    // Acceptance decision for the field presented this cycle.
    always_comb begin
        accept = field_valid && pid_armed && (pid_kind != TK_NONE) && !crc5_err
                 && enable && (field_bits[ADDR_W-1:0] == dev_addr);
        hit_vec = accept ? kind_onehot(pid_kind) : '0;
    end

    // Register the one-cycle pulse and latch the endpoint of an accepted token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_pulse <= '0;
            tok_ep    <= '0;
        end else begin
            tok_pulse <= hit_vec;
            if (accept) begin
                tok_ep <= field_bits[FIELD_W-1:ADDR_W];
            end
        end
    end

    usb_tok_flags #(.N(NK)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (hit_vec),
        .clr  (flag_clr),
        .flags(tok_flags)
    );

    // Power-down request to the transceiver follows the enable bit.
    always_comb xcvr_pdn = !enable;

endmodule

// File: rtl/usb_token_filter_chk.sv
// Module: assertion checker for usb_token_filter, attached by bind below.
// Assumes the default widths of the top module.
module usb_token_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_reset,
    input logic [7:0]  cfg_rdata,
    input logic        field_valid,
    input logic [10:0] field_bits,
    input logic [2:0]  flag_clr,
    input logic [2:0]  tok_pulse,
    input logic [2:0]  tok_flags
);

    // Bus reset empties the register by the next cycle.
    p_busreset_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> cfg_rdata == 8'h00);

    // At most one token type pulses at a time.
    p_pulse_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok_pulse));

    // A pulse always follows a field strobe.
    p_pulse_after_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_pulse != 3'b000) |-> $past(field_valid));

    // A pulse requires the field address to have matched the stored one.
    p_addr_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_pulse != 3'b000) |-> ($past(field_bits[6:0]) == $past(cfg_rdata[6:0])));

    // No pulse unless the block was enabled when the field arrived.
    p_enabled_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_pulse != 3'b000) |-> $past(cfg_rdata[7]));

    // Every pulsed type is also flagged.
    p_pulse_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_pulse & ~tok_flags) == 3'b000);

    // A flag only drops after a clear strobe on its bit.
    p_flag_drop_needs_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tok_flags) & ~tok_flags & ~$past(flag_clr)) == 3'b000);

endmodule

bind usb_token_filter usb_token_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .cfg_rdata  (cfg_rdata),
    .field_valid(field_valid),
    .field_bits (field_bits),
    .flag_clr   (flag_clr),
    .tok_pulse  (tok_pulse),
    .tok_flags  (tok_flags)
);

// File: tb/usb_token_filter_tb.sv
// Bench: table-driven token sweep, then directed tests for reset and corner cases.
module usb_token_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        xcvr_pdn;
    logic        pid_valid = 1'b0;
    logic [7:0]  pid_byte = '0;
    logic        field_valid = 1'b0;
    logic [10:0] field_bits = '0;
    logic        crc5_err = 1'b0;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  tok_pulse;
    logic [3:0]  tok_ep;
    logic [2:0]  tok_flags;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_token_filter u_dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .xcvr_pdn(xcvr_pdn), .pid_valid(pid_valid), .pid_byte(pid_byte),
        .field_valid(field_valid), .field_bits(field_bits), .crc5_err(crc5_err),
        .flag_clr(flag_clr), .tok_pulse(tok_pulse), .tok_ep(tok_ep),
        .tok_flags(tok_flags)
    );

    localparam logic [6:0] DEV = 7'h2A;
    // Vector: {pid, ep, addr, crc_err, expected pulse}
    localparam int NV = 9;
    localparam logic [22:0] VECS [NV] = '{
        {8'hE1, 4'd1,  DEV,   1'b0, 3'b001},  // OUT match
        {8'h69, 4'd3,  DEV,   1'b0, 3'b010},  // IN match
        {8'h2D, 4'd0,  DEV,   1'b0, 3'b100},  // SETUP match
        {8'h69, 4'd2,  7'h2B, 1'b0, 3'b000},  // address mismatch
        {8'hE1, 4'd5,  DEV,   1'b1, 3'b000},  // crc5 error
        {8'hE9, 4'd1,  DEV,   1'b0, 3'b000},  // nibble check fails
        {8'hC3, 4'd1,  DEV,   1'b0, 3'b000},  // data PID, not a token
        {8'h2D, 4'd15, DEV,   1'b0, 3'b100},  // SETUP top endpoint
        {8'hE1, 4'd7,  7'h00, 1'b0, 3'b000}   // address zero mismatch
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Send PID then field; returns at the negedge where the pulse is visible.
    task automatic send_tok(input logic [7:0] pid, input logic [10:0] fld, input logic crc);
        pid_valid = 1'b1; pid_byte = pid;
        tick();
        pid_valid = 1'b0;
        field_valid = 1'b1; field_bits = fld; crc5_err = crc;
        tick();
        field_valid = 1'b0; crc5_err = 1'b0;
    endtask

    task automatic clear_all();
        flag_clr = 3'b111;
        tick();
        flag_clr = 3'b000;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 0);
        chk("R1 xcvr_pdn", xcvr_pdn, 1);
        chk("R1 tok_flags", tok_flags, 0);
        chk("R1 tok_pulse", tok_pulse, 0);

        // R7 disabled: matching token ignored
        write_cfg({1'b0, DEV});
        chk("R4 pdn while disabled", xcvr_pdn, 1);
        send_tok(8'hE1, {4'd2, DEV}, 1'b0);
        chk("R7 no pulse while disabled", tok_pulse, 0);
        tick();
        chk("R7 no flag while disabled", tok_flags, 0);

        // R2 write and R4 power-down
        write_cfg({1'b1, DEV});
        chk("R2 cfg_rdata", cfg_rdata, {1'b1, DEV});
        chk("R4 pdn while enabled", xcvr_pdn, 0);

        // Table sweep: R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VECS[i];
            clear_all();
            send_tok(v[22:15], v[14:4], v[3]);
            chk($sformatf("R5 pulse vec%0d", i), tok_pulse, v[2:0]);
            if (v[2:0] != 3'b000)
                chk($sformatf("R5 ep vec%0d", i), tok_ep, v[14:11]);
            tick();
            chk($sformatf("R5 pulse gone vec%0d", i), tok_pulse, 0);
            chk($sformatf("R10 flags vec%0d", i), tok_flags, v[2:0]);
        end

        // R11 field without a new PID after an accepted token
        clear_all();
        send_tok(8'h69, {4'd4, DEV}, 1'b0);
        chk("R11 first accepted", tok_pulse, 3'b010);
        field_valid = 1'b1; field_bits = {4'd6, DEV};
        tick();
        field_valid = 1'b0;
        chk("R11 stray field ignored", tok_pulse, 0);
        chk("R11 ep unchanged", tok_ep, 4);

        // R10 sticky across tokens, W1C, and set winning over clear
        clear_all();
        send_tok(8'hE1, {4'd1, DEV}, 1'b0);
        send_tok(8'h2D, {4'd0, DEV}, 1'b0);
        chk("R10 flags accumulate", tok_flags, 3'b101);
        flag_clr = 3'b100;
        tick();
        flag_clr = 3'b000;
        chk("R10 w1c clears one bit", tok_flags, 3'b001);
        pid_valid = 1'b1; pid_byte = 8'hE1;
        tick();
        pid_valid = 1'b0;
        field_valid = 1'b1; field_bits = {4'd1, DEV}; flag_clr = 3'b001;
        tick();
        field_valid = 1'b0; flag_clr = 3'b000;
        chk("R10 set beats clear", tok_flags, 3'b001);

        // R3 bus reset outranks a write
        bus_reset = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'hFF;
        tick();
        bus_reset = 1'b0; cfg_we = 1'b0;
        chk("R3 bus reset clears", cfg_rdata, 0);
        chk("R4 pdn after bus reset", xcvr_pdn, 1);
        send_tok(8'h69, {4'd1, 7'h00}, 1'b0);
        chk("R7 address zero ignored after bus reset", tok_pulse, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule